// File: doc/BRIEF.md
# Gigabit Ethernet Ordered Set Classifier

This block watches a stream of already-decoded code groups, one per clock. Each group is an 8-bit value plus a flag that marks control groups. The block recognises the ordered sets and special code groups of gigabit Ethernet framing. For each set it recognises, it raises a class strobe for one cycle together with a class code. Nothing is reported for data groups that arrive outside a set.

Multi-group sets begin with the comma control group (K28.5, byte 0xBC). The data group after the comma tells which set it is. The two configuration sets carry two further data groups, which together hold a 16-bit configuration word. The block assembles that word and signals it with a valid pulse. An input-valid qualifier lets the upstream decoder leave cycles empty. An empty cycle changes nothing. The block does not decode 8b/10b, check running disparity or run autonegotiation.

Top module: `gbe_oset_classifier`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, classStrobe and cfgValid are 0, classCode is 0 (none) and cfgReg is 0. A set that was partly received when reset came is abandoned.
- R2: A comma (inCtrl=1, inData=0xBC) followed by the data group 0xC5 is reported as idle-1 (classCode 3). A comma followed by the data group 0xD0 is not idle-2; idle-2 is the comma followed by the data group 0x50 (classCode 4). The strobe is seen in the cycle after the clock edge that samples the second group.
- R3: A comma followed by the data group 0xB5 is reported as configuration-1 (classCode 1). A comma followed by the data group 0x42 is reported as configuration-2 (classCode 2). Both are reported in the cycle after the second group is sampled.
- R4: After a configuration set is identified, the next two valid data groups form cfgReg. The first of them is the low byte and the second is the high byte. cfgValid pulses for one cycle, in the cycle after the fourth group is sampled, and cfgReg takes its new value in that same cycle.
- R5: The single control groups are reported in the cycle after they are sampled: 0xF7 as carrier-extend (classCode 5), 0xFB as start (6), 0xFD as end (7) and 0xFE as error-propagation (8).
- R6: A comma followed by any other data group, or by any control group, is reported as unknown (classCode 9). If that second group is itself a comma, it opens a new set. Any other control group in that position is consumed and gets no report of its own.
- R7: A control group that arrives in place of either configuration data group ends the set without a cfgValid pulse and leaves cfgReg unchanged. That control group is then classified as if no set were open.
- R8: A cycle with inValid=0 is ignored. It causes no strobe, no cfgValid and no change of progress through a set.
- R9: classCode is 0 whenever classStrobe is 0. A data group seen while no set is open produces no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | The code group on inData/inCtrl is valid this cycle |
| inData | input | 8 | Decoded code group value |
| inCtrl | input | 1 | 1 = control group, 0 = data group |
| classStrobe | output | 1 | One-cycle pulse when a set or special group is recognised |
| classCode | output | 4 | Class of the recognised set; 0 when no strobe |
| cfgValid | output | 1 | One-cycle pulse when a new configuration word is on cfgReg |
| cfgReg | output | 16 | Last complete configuration word |

## Verification
The assertions assume that every code group that matters is qualified by inValid. They also assume that inputs are stable and defined at every sampling edge after reset, and that inValid is held low during reset. The bench meets this by driving all inputs on the falling edge and keeping inValid at 0 during every reset phase. Idle gaps are inserted only as whole cycles with inValid=0, and in those cycles inData and inCtrl are held at known values.

// File: rtl/gbe_oset_pkg.sv
package gbe_oset_pkg;

  localparam int GROUP_W = 8;

  // Byte values of the code groups the classifier knows
  localparam logic [GROUP_W-1:0] COMMA_BYTE = 8'hBC;
  localparam logic [GROUP_W-1:0] CFG1_TAG   = 8'hB5;
  localparam logic [GROUP_W-1:0] CFG2_TAG   = 8'h42;
  localparam logic [GROUP_W-1:0] IDLE1_TAG  = 8'hC5;
  localparam logic [GROUP_W-1:0] IDLE2_TAG  = 8'h50;
  localparam logic [GROUP_W-1:0] EXT_BYTE   = 8'hF7;
  localparam logic [GROUP_W-1:0] SOP_BYTE   = 8'hFB;
  localparam logic [GROUP_W-1:0] EOP_BYTE   = 8'hFD;
  localparam logic [GROUP_W-1:0] ERR_BYTE   = 8'hFE;

  localparam int CLASS_W = 4;

  typedef enum logic [CLASS_W-1:0] {
    CLS_NONE = 4'd0,
    CLS_CFG1 = 4'd1,
    CLS_CFG2 = 4'd2,
    CLS_IDL1 = 4'd3,
    CLS_IDL2 = 4'd4,
    CLS_EXT  = 4'd5,
    CLS_SOP  = 4'd6,
    CLS_EOP  = 4'd7,
    CLS_ERR  = 4'd8,
    CLS_UNK  = 4'd9
  } clsE;

  // Match flags from the datapath for the current group
  typedef struct packed {
    logic valid;
    logic isCtrl;
    logic isComma;
    logic tagCfg1;
    logic tagCfg2;
    logic tagIdl1;
    logic tagIdl2;
    logic isExt;
    logic isSop;
    logic isEop;
    logic isErr;
  } decodeT;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic emit;
    clsE  code;
    logic loadLo;
    logic loadHi;
  } strobeT;

endpackage

// File: rtl/gbe_oset_dp.sv
module gbe_oset_dp
  import gbe_oset_pkg::*;
#(
  parameter int DW = GROUP_W,
  parameter logic [DW-1:0] COMMA = COMMA_BYTE,
  parameter logic [DW-1:0] TAG_C1 = CFG1_TAG,
  parameter logic [DW-1:0] TAG_C2 = CFG2_TAG,
  parameter logic [DW-1:0] TAG_I1 = IDLE1_TAG,
  parameter logic [DW-1:0] TAG_I2 = IDLE2_TAG,
  parameter logic [DW-1:0] SP_EXT = EXT_BYTE,
  parameter logic [DW-1:0] SP_SOP = SOP_BYTE,
  parameter logic [DW-1:0] SP_EOP = EOP_BYTE,
  parameter logic [DW-1:0] SP_ERR = ERR_BYTE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DW-1:0]     inData,
  input  logic              inCtrl,
  input  strobeT            stb,
  output decodeT            dec,
  output logic              classStrobe,
  output logic [CLASS_W-1:0] classCode,
  output logic              cfgValid,
  output logic [2*DW-1:0]   cfgReg
);

  localparam int NTAG = 4;
  localparam int NSP  = 4;
  localparam logic [DW-1:0] TAGS [NTAG] = '{TAG_C1, TAG_C2, TAG_I1, TAG_I2};
  localparam logic [DW-1:0] SPS  [NSP]  = '{SP_EXT, SP_SOP, SP_EOP, SP_ERR};

  logic [NTAG-1:0] tagHit;
  logic [NSP-1:0]  spHit;

  // Data-group tag comparators
  for (genvar t = 0; t < NTAG; t++) begin : g_tag
    assign tagHit[t] = !inCtrl && (inData == TAGS[t]);
  end

  // Single control-group comparators
  for (genvar s = 0; s < NSP; s++) begin : g_sp
    assign spHit[s] = inCtrl && (inData == SPS[s]);
  end

  always_comb begin
    dec.valid   = inValid;
    dec.isCtrl  = inCtrl;
    dec.isComma = inCtrl && (inData == COMMA);
    dec.tagCfg1 = tagHit[0];
    dec.tagCfg2 = tagHit[1];
    dec.tagIdl1 = tagHit[2];
    dec.tagIdl2 = tagHit[3];
    dec.isExt   = spHit[0];
    dec.isSop   = spHit[1];
    dec.isEop   = spHit[2];
    dec.isErr   = spHit[3];
  end

  logic [DW-1:0] loByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      classStrobe <= 1'b0;
      classCode   <= CLS_NONE;
      cfgValid    <= 1'b0;
      cfgReg      <= '0;
      loByte      <= '0;
    end else begin
      classStrobe <= stb.emit;
      classCode   <= stb.emit ? stb.code : CLS_NONE;
      cfgValid    <= stb.loadHi;
      if (stb.loadLo) loByte <= inData;
      if (stb.loadHi) cfgReg <= {inData, loByte};
    end
  end

endmodule

// File: rtl/gbe_oset_ctl.sv
module gbe_oset_ctl
  import gbe_oset_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  decodeT dec,
  output strobeT stb
);

  typedef enum logic [1:0] {
    ST_OPEN  = 2'd0,
    ST_COMMA = 2'd1,
    ST_CFGLO = 2'd2,
    ST_CFGHI = 2'd3
  } stateE;

  stateE state, stateNext;

  // Classification of a group when no set is open
  function automatic void freshGroup(input decodeT d, output strobeT s,
                                     output stateE n);
    s = '{emit: 1'b0, code: CLS_NONE, loadLo: 1'b0, loadHi: 1'b0};
    n = ST_OPEN;
    if (d.isComma) begin
      n = ST_COMMA;
    end else if (d.isExt) begin
      s.emit = 1'b1; s.code = CLS_EXT;
    end else if (d.isSop) begin
      s.emit = 1'b1; s.code = CLS_SOP;
    end else if (d.isEop) begin
      s.emit = 1'b1; s.code = CLS_EOP;
    end else if (d.isErr) begin
      s.emit = 1'b1; s.code = CLS_ERR;
    end
  endfunction

  always_comb begin
    stb = '{emit: 1'b0, code: CLS_NONE, loadLo: 1'b0, loadHi: 1'b0};
    stateNext = state;
    if (dec.valid) begin
      unique case (state)
        ST_OPEN: freshGroup(dec, stb, stateNext);
        ST_COMMA: begin
          stb.emit  = 1'b1;
          stateNext = ST_OPEN;
          if (dec.isCtrl) begin
            stb.code = CLS_UNK;
            if (dec.isComma) stateNext = ST_COMMA;
          end else if (dec.tagCfg1) begin
            stb.code  = CLS_CFG1;
            stateNext = ST_CFGLO;
          end else if (dec.tagCfg2) begin
            stb.code  = CLS_CFG2;
            stateNext = ST_CFGLO;
          end else if (dec.tagIdl1) begin
            stb.code = CLS_IDL1;
          end else if (dec.tagIdl2) begin
            stb.code = CLS_IDL2;
          end else begin
            stb.code = CLS_UNK;
          end
        end
        ST_CFGLO: begin
          if (dec.isCtrl) freshGroup(dec, stb, stateNext);
          else begin
            stb.loadLo = 1'b1;
            stateNext  = ST_CFGHI;
          end
        end
        ST_CFGHI: begin
          if (dec.isCtrl) freshGroup(dec, stb, stateNext);
          else begin
            stb.loadHi = 1'b1;
            stateNext  = ST_OPEN;
          end
        end
        default: stateNext = ST_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OPEN;
    else       state <= stateNext;
  end

endmodule

// File: rtl/gbe_oset_classifier.sv
module gbe_oset_classifier
  import gbe_oset_pkg::*;
#(
  parameter int DW = GROUP_W,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [DW-1:0] inData,
  input  logic          inCtrl,
  output logic          classStrobe,
  output logic [CLASS_W-1:0] classCode,
  output logic          cfgValid,
  output logic [CW-1:0] cfgReg
);

  decodeT dec;
  strobeT stb;

  gbe_oset_dp #(.DW(DW)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .inData      (inData),
    .inCtrl      (inCtrl),
    .stb         (stb),
    .dec         (dec),
    .classStrobe (classStrobe),
    .classCode   (classCode),
    .cfgValid    (cfgValid),
    .cfgReg      (cfgReg)
  );

  gbe_oset_ctl ctl_i (
    .clk  (clk),
    .rstN (rstN),
    .dec  (dec),
    .stb  (stb)
  );

endmodule

// File: rtl/gbe_oset_classifier_chk.sv
module gbe_oset_classifier_chk
  import gbe_oset_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [7:0]   inData,
  input logic         inCtrl,
  input logic         classStrobe,
  input logic [3:0]   classCode,
  input logic         cfgValid
);

  // R9
  code_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !classStrobe |-> classCode == CLS_NONE);

  // R8
  gap_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!classStrobe && !cfgValid));

  // R4
  cfg_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> !cfgValid);

  // R4
  cfg_from_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> $past(inValid && !inCtrl));

  // R5
  ext_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (classStrobe && classCode == CLS_EXT) |-> $past(inCtrl && inData == EXT_BYTE));

  // R2
  idle1_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (classStrobe && classCode == CLS_IDL1) |-> $past(!inCtrl && inData == IDLE1_TAG));

  // R8
  strobe_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    classStrobe |-> $past(inValid));

endmodule

bind gbe_oset_classifier gbe_oset_classifier_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inData      (inData),
  .inCtrl      (inCtrl),
  .classStrobe (classStrobe),
  .classCode   (classCode),
  .cfgValid    (cfgValid)
);

// File: tb/gbe_oset_classifier_tb.sv
module gbe_oset_classifier_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inCtrl = 1'b0;
  logic        classStrobe;
  logic [3:0]  classCode;
  logic        cfgValid;
  logic [15:0] cfgReg;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gbe_oset_classifier dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inCtrl(inCtrl),
    .classStrobe(classStrobe), .classCode(classCode),
    .cfgValid(cfgValid), .cfgReg(cfgReg)
  );

  typedef struct packed {
    logic        v;
    logic        c;
    logic [7:0]  d;
    logic        s;
    logic [3:0]  k;
    logic        cv;
    logic [15:0] cfg;
  } vecT;

  localparam int NV = 34;
  localparam vecT VECS [NV] = '{
    '{1'b0,1'b0,8'h00,1'b0,4'd0,1'b0,16'h0000}, // R8 empty cycle
    '{1'b1,1'b1,8'hBC,1'b0,4'd0,1'b0,16'h0000}, // comma
    '{1'b1,1'b0,8'hC5,1'b1,4'd3,1'b0,16'h0000}, // R2 idle-1
    '{1'b1,1'b1,8'hBC,1'b0,4'd0,1'b0,16'h0000},
    '{1'b1,1'b0,8'h50,1'b1,4'd4,1'b0,16'h0000}, // R2 idle-2
    '{1'b1,1'b1,8'hBC,1'b0,4'd0,1'b0,16'h0000},
    '{1'b1,1'b0,8'hB5,1'b1,4'd1,1'b0,16'h0000}, // R3 config-1
    '{1'b1,1'b0,8'h34,1'b0,4'd0,1'b0,16'h0000}, // R4 low byte
    '{1'b1,1'b0,8'h12,1'b0,4'd0,1'b1,16'h1234}, // R4 high byte
    '{1'b1,1'b1,8'hBC,1'b0,4'd0,1'b0,16'h0000},
    '{1'b1,1'b0,8'h42,1'b1,4'd2,1'b0,16'h0000}, // R3 config-2
    '{1'b1,1'b0,8'hCD,1'b0,4'd0,1'b0,16'h0000},
    '{1'b1,1'b0,8'hAB,1'b0,4'd0,1'b1,16'hABCD}, // R4
    '{1'b1,1'b1,8'hFB,1'b1,4'd6,1'b0,16'h0000}, // R5 start
    '{1'b1,1'b0,8'h55,1'b0,4'd0,1'b0,16'h0000}, // R9 loose data
    '{1'b1,1'b1,8'hFD,1'b1,4'd7,1'b0,16'h0000}, // R5 end
    '{1'b1,1'b1,8'hF7,1'b1,4'd5,1'b0,16'h0000}, // R5 extend
    '{1'b1,1'b1,8'hFE,1'b1,4'd8,1'b0,16'h0000}, // R5 error
    '{1'b1,1'b1,8'hBC,1'b0,4'd0,1'b0,16'h0000},
    '{1'b1,1'b0,8'h77,1'b1,4'd9,1'b0,16'h0000}, // R6 bad data tag
    '{1'b1,1'b1,8'hBC,1'b0,4'd0,1'b0,16'h0000},
    '{1'b1,1'b1,8'hFB,1'b1,4'd9,1'b0,16'h0000}, // R6 control after comma
    '{1'b1,1'b1,8'hFB,1'b1,4'd6,1'b0,16'h0000}, // R6 back to open
    '{1'b1,1'b1,8'hBC,1'b0,4'd0,1'b0,16'h0000},
    '{1'b0,1'b0,8'h00,1'b0,4'd0,1'b0,16'h0000}, // R8 gap inside set
    '{1'b1,1'b0,8'hC5,1'b1,4'd3,1'b0,16'h0000}, // R8 progress kept
    '{1'b1,1'b1,8'hBC,1'b0,4'd0,1'b0,16'h0000},
    '{1'b1,1'b0,8'hB5,1'b1,4'd1,1'b0,16'h0000},
    '{1'b1,1'b0,8'h11,1'b0,4'd0,1'b0,16'h0000},
    '{1'b1,1'b1,8'hFD,1'b1,4'd7,1'b0,16'h0000}, // R7 abort, reclassified
    '{1'b1,1'b0,8'h22,1'b0,4'd0,1'b0,16'h0000}, // R7 no pulse
    '{1'b1,1'b1,8'hBC,1'b0,4'd0,1'b0,16'h0000},
    '{1'b1,1'b1,8'hBC,1'b1,4'd9,1'b0,16'h0000}, // R6 comma reopens
    '{1'b1,1'b0,8'h50,1'b1,4'd4,1'b0,16'h0000}  // R6 idle-2 after reopen
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic c, input logic [7:0] d);
    inValid = v; inCtrl = c; inData = d;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected<=5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 state during reset
    check(classStrobe == 1'b0, "R1", "strobe in reset", classStrobe, 0);
    check(classCode == 4'd0, "R1", "code in reset", classCode, 0);
    check(cfgValid == 1'b0, "R1", "cfgValid in reset", cfgValid, 0);
    check(cfgReg == 16'h0, "R1", "cfgReg in reset", cfgReg, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(classStrobe == 1'b0 && classCode == 4'd0, "R1", "strobe after reset",
          {classStrobe, classCode}, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].v, VECS[i].c, VECS[i].d);
      check(classStrobe == VECS[i].s && classCode == VECS[i].k,
            $sformatf("vec%0d", i), "strobe/code",
            {classStrobe, classCode}, {VECS[i].s, VECS[i].k});
      check(cfgValid == VECS[i].cv && (!VECS[i].cv || cfgReg == VECS[i].cfg),
            $sformatf("vec%0d", i), "cfgValid/cfgReg",
            {cfgValid, cfgReg}, {VECS[i].cv, VECS[i].cfg});
    end

    // R7 aborted set left the word alone
    check(cfgReg == 16'hABCD, "R7", "cfgReg kept after abort", cfgReg, 16'hABCD);

    // R1 reset in the middle of a configuration set
    drive(1'b1, 1'b1, 8'hBC);
    drive(1'b1, 1'b0, 8'hB5);
    drive(1'b1, 1'b0, 8'h11);
    inValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    check(cfgReg == 16'h0 && cfgValid == 1'b0, "R1", "reset mid-set",
          {cfgValid, cfgReg}, 0);
    rstN = 1'b1;
    @(negedge clk);
    drive(1'b1, 1'b0, 8'h22);
    check(cfgValid == 1'b0 && classStrobe == 1'b0, "R1", "abandoned set low byte",
          {cfgValid, classStrobe}, 0);
    drive(1'b1, 1'b0, 8'h33);
    check(cfgValid == 1'b0 && classStrobe == 1'b0, "R1", "abandoned set high byte",
          {cfgValid, classStrobe}, 0);
    check(cfgReg == 16'h0, "R1", "cfgReg after abandoned set", cfgReg, 0);

    // R9 data tag without comma
    drive(1'b1, 1'b0, 8'hC5);
    check(classStrobe == 1'b0 && classCode == 4'd0, "R9", "tag without comma",
          {classStrobe, classCode}, 0);

    // R8 comma then gaps then tag
    drive(1'b1, 1'b1, 8'hBC);
    drive(1'b0, 1'b1, 8'hFB);
    check(classStrobe == 1'b0, "R8", "invalid control ignored", classStrobe, 0);
    drive(1'b1, 1'b0, 8'hB5);
    check(classStrobe && classCode == 4'd1, "R8", "set survives gap",
          {classStrobe, classCode}, 5'h11);
    drive(1'b1, 1'b0, 8'h0F);
    drive(1'b0, 1'b0, 8'hEE);
    check(cfgValid == 1'b0, "R8", "no pulse on gap", cfgValid, 0);
    drive(1'b1, 1'b0, 8'hF0);
    check(cfgValid && cfgReg == 16'hF00F, "R4", "word across gap",
          {cfgValid, cfgReg}, 17'h1F00F);
    drive(1'b0, 1'b0, 8'h00);
    check(cfgValid == 1'b0 && cfgReg == 16'hF00F, "R4", "pulse one cycle",
          {cfgValid, cfgReg}, 17'h0F00F);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule